// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Guarded Accumulators

This block is the arithmetic core of a fixed-point signal processor's data path. It holds four 24-bit signed source registers and two 56-bit accumulators. Each accumulator is laid out as an 8-bit guard extension (bits 55:48), a 24-bit high word (bits 47:24) and a 24-bit low word (bits 23:0). In each cycle one operation can run: multiply, multiply-accumulate, or multiply-subtract, each with or without round-half-to-even. There are also two direct operations that add a source register to an accumulator or subtract one from it. Every operation completes in the clock edge that samples it, so its result is in the accumulator one cycle later.

Operands are signed fractions. The 48-bit product is sign-extended to 56 bits and doubled, which drops the redundant sign bit. The extension bits hold growth above the plus-or-minus 1.0 range. Arithmetic wraps at 56 bits and is never clamped inside the unit. Results go only to the accumulator chosen by the select input. Source registers are loaded through a separate write port that can be used in the same cycle as an operation.

Top module: `frac_mac`

## Requirements
- R1: After reset both accumulators read zero, and all four source registers hold zero, so a multiply issued before any write yields zero.
- R2: When `wr_en` is high, `wr_data` is stored at the clock edge into source register `wr_sel` (0 to 3). An operation sampled at that same edge uses the register's previous contents.
- R3: Operation code 0 (multiply) loads the selected accumulator with the 48-bit signed product of registers `src_a_sel` and `src_b_sel`, sign-extended to 56 bits and shifted left by one. The value is visible one cycle after `op_valid` is sampled high.
- R4: Operation code 2 (multiply-accumulate) adds that product to the selected accumulator.
- R5: Operation code 4 (multiply-subtract) subtracts that product from the selected accumulator.
- R6: Codes 1, 3 and 5 are codes 0, 2 and 4 with convergent rounding applied to the 56-bit result. The unit adds 0x800000 to it. If the low word was exactly 0x800000 before that add, it clears bit 24. It then clears bits 23:0.
- R7: Code 6 adds, and code 7 subtracts, register `src_a_sel` to or from the selected accumulator. The register is aligned as bits 47:24, sign-extended through bits 55:48, with the low word zero. `src_b_sel` has no effect on these codes.
- R8: Only the accumulator named by `acc_sel` (0 or 1) can change. While `op_valid` is low, neither accumulator changes.
- R9: Accumulator arithmetic wraps modulo 2^56, with no saturation. Growth past bit 47 goes into the extension bits.
- R10: The product of -1.0 by -1.0 (0x800000 times 0x800000) gives +1.0, 0x00_800000_000000, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Source register write strobe |
| wr_sel | input | 2 | Source register to write |
| wr_data | input | 24 | Value to write |
| op_valid | input | 1 | Operation issue strobe |
| op_code | input | 3 | Operation code (0 to 7, see R3 to R7) |
| src_a_sel | input | 2 | First source register |
| src_b_sel | input | 2 | Second source register (multiplier only) |
| acc_sel | input | 1 | Destination accumulator |
| acc0_out | output | 56 | Accumulator 0 |
| acc1_out | output | 56 | Accumulator 1 |

## Verification
Every result appears exactly one clock after the edge that samples its stimulus. A register write can be seen only through an operation issued at least one edge later. An operation's result is on its accumulator port after that same edge. The bench drives each stimulus just after a falling edge and clears it at the next falling edge. It samples both accumulator ports at that second falling edge, which is half a period after the result edge, so no check races the edge. Same-edge write-and-use is tested on purpose to pin down the old-value behaviour.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  localparam int unsigned WORD_W  = 24;
  localparam int unsigned GUARD_W = 8;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned NUM_ACC = 2;

  typedef enum logic [2:0] {
    OP_MPY   = 3'd0,
    OP_MPYR  = 3'd1,
    OP_MAC   = 3'd2,
    OP_MACR  = 3'd3,
    OP_MACN  = 3'd4,
    OP_MACNR = 3'd5,
    OP_ADD   = 3'd6,
    OP_SUB   = 3'd7
  } mac_op_e;
endpackage

// File: rtl/mac_src_regs.sv
module mac_src_regs #(
  parameter int unsigned WORD_W  = 24,
  parameter int unsigned NUM_SRC = 4,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SEL_W-1:0]                 wr_sel,
  input  logic [WORD_W-1:0]                wr_data,
  output logic [NUM_SRC-1:0][WORD_W-1:0]   regs_q
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic              load_en;
    logic [WORD_W-1:0] reg_d;

    always_comb begin
      load_en = wr_en && (wr_sel == SEL_W'(g));
      reg_d   = load_en ? wr_data : regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= reg_d;
    end
  end

  // R2: a strobed write lands in the addressed register
  assert_reg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import frac_mac_pkg::*;
#(
  parameter int unsigned WORD_W  = 24,
  parameter int unsigned GUARD_W = 8,
  localparam int unsigned ACC_W  = GUARD_W + 2 * WORD_W,
  localparam int unsigned PROD_W = 2 * WORD_W
) (
  input  mac_op_e            op,
  input  logic [WORD_W-1:0]  opa,
  input  logic [WORD_W-1:0]  opb,
  input  logic [ACC_W-1:0]   acc_in,
  output logic [ACC_W-1:0]   acc_next,
  output logic               round_on
);
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_sx;
  logic [ACC_W-1:0]         prod_frac;
  logic [ACC_W-1:0]         opnd_al;
  logic [ACC_W-1:0]         addend;
  logic [ACC_W-1:0]         base;
  logic                     negate;
  logic [ACC_W-1:0]         sum;
  logic                     tie;
  logic [ACC_W-1:0]         rounded;

  always_comb begin
    prod      = $signed(opa) * $signed(opb);
    prod_sx   = ACC_W'(prod);
    prod_frac = {prod_sx[ACC_W-2:0], 1'b0};
    opnd_al   = {{GUARD_W{opa[WORD_W-1]}}, opa, {WORD_W{1'b0}}};

    base   = (op == OP_MPY || op == OP_MPYR) ? '0 : acc_in;
    addend = (op == OP_ADD || op == OP_SUB) ? opnd_al : prod_frac;
    negate = (op == OP_MACN) || (op == OP_MACNR) || (op == OP_SUB);
    sum    = negate ? (base - addend) : (base + addend);

    round_on = (op == OP_MPYR) || (op == OP_MACR) || (op == OP_MACNR);
    tie      = (sum[WORD_W-1:0] == {1'b1, {(WORD_W-1){1'b0}}});
    rounded  = sum + ACC_W'({1'b1, {(WORD_W-1){1'b0}}});
    if (tie) rounded[WORD_W] = 1'b0;
    rounded[WORD_W-1:0] = '0;

    acc_next = round_on ? rounded : sum;
  end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
  parameter int unsigned ACC_W   = 56,
  parameter int unsigned LOW_W   = 24,
  parameter int unsigned NUM_ACC = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_ACC-1:0]              we,
  input  logic                            rnd,
  input  logic [ACC_W-1:0]                d,
  output logic [NUM_ACC-1:0][ACC_W-1:0]   q
);
  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    logic [ACC_W-1:0] acc_d;

    always_comb acc_d = we[g] ? d : q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= '0;
      else        q[g] <= acc_d;
    end

    // R8: an accumulator not written this cycle keeps its value
    assert_hold_unselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !we[g] |=> q[g] == $past(q[g]));

    // R6: a rounded result leaves an empty low word
    assert_round_low_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we[g] && rnd) |=> q[g][LOW_W-1:0] == '0);
  end
endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import frac_mac_pkg::*;
#(
  parameter int unsigned WORD_W  = frac_mac_pkg::WORD_W,
  parameter int unsigned GUARD_W = frac_mac_pkg::GUARD_W,
  parameter int unsigned NUM_SRC = frac_mac_pkg::NUM_SRC,
  localparam int unsigned ACC_W  = GUARD_W + 2 * WORD_W,
  localparam int unsigned SEL_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [SEL_W-1:0]  src_a_sel,
  input  logic [SEL_W-1:0]  src_b_sel,
  input  logic              acc_sel,
  output logic [ACC_W-1:0]  acc0_out,
  output logic [ACC_W-1:0]  acc1_out
);
  localparam int unsigned N_ACC = 2;

  logic [NUM_SRC-1:0][WORD_W-1:0] src_q;
  logic [N_ACC-1:0][ACC_W-1:0]    acc_q;
  logic [N_ACC-1:0]               acc_we;
  logic [WORD_W-1:0]              opa;
  logic [WORD_W-1:0]              opb;
  logic [ACC_W-1:0]               acc_cur;
  logic [ACC_W-1:0]               acc_nxt;
  logic                           rnd;
  mac_op_e                        op;

  mac_src_regs #(.WORD_W(WORD_W), .NUM_SRC(NUM_SRC)) u_src (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .regs_q(src_q)
  );

  always_comb begin
    op      = mac_op_e'(op_code);
    opa     = src_q[src_a_sel];
    opb     = src_q[src_b_sel];
    acc_cur = acc_q[acc_sel];
    acc_we  = '0;
    acc_we[acc_sel] = op_valid;
  end

  mac_datapath #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_dp (
    .op(op), .opa(opa), .opb(opb), .acc_in(acc_cur),
    .acc_next(acc_nxt), .round_on(rnd)
  );

  mac_acc_bank #(.ACC_W(ACC_W), .LOW_W(WORD_W), .NUM_ACC(N_ACC)) u_acc (
    .clk(clk), .rst_n(rst_n), .we(acc_we), .rnd(rnd), .d(acc_nxt), .q(acc_q)
  );

  assign acc0_out = acc_q[0];
  assign acc1_out = acc_q[1];

  // R3: a multiply with a zero source leaves zero in the destination
  assert_mpy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd0 && (opa == '0 || opb == '0))
      |=> acc_q[$past(acc_sel)] == '0);

  // R8: with no issue, both accumulators hold
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (acc0_out == $past(acc0_out)) && (acc1_out == $past(acc1_out)));
endmodule

// File: tb/tb_frac_mac.sv
module tb_frac_mac;
  localparam logic [2:0] C_MPY = 3'd0, C_MPYR = 3'd1, C_MAC = 3'd2, C_MACR = 3'd3,
                         C_MACN = 3'd4, C_MACNR = 3'd5, C_ADD = 3'd6, C_SUB = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [23:0] wr_data = '0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [1:0]  src_a_sel = '0;
  logic [1:0]  src_b_sel = '0;
  logic        acc_sel = 1'b0;
  logic [55:0] acc0_out, acc1_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  frac_mac dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .op_valid(op_valid), .op_code(op_code), .src_a_sel(src_a_sel),
    .src_b_sel(src_b_sel), .acc_sel(acc_sel), .acc0_out(acc0_out), .acc1_out(acc1_out)
  );

  task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%014h expected=%014h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] ws, input logic [23:0] wd,
                      input logic ov, input logic [2:0] oc, input logic [1:0] sa,
                      input logic [1:0] sb, input logic as);
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd;
    op_valid = ov; op_code = oc; src_a_sel = sa; src_b_sel = sb; acc_sel = as;
    @(negedge clk);
    wr_en = 1'b0; op_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [23:0] d);
    step(1'b1, s, d, 1'b0, C_MAC, 2'd0, 2'd0, 1'b0);
  endtask

  task automatic op(input logic [2:0] c, input logic [1:0] a, input logic [1:0] b, input logic t);
    step(1'b0, 2'd0, 24'h0, 1'b1, c, a, b, t);
  endtask

  task automatic t_reset;
    chk("R1 acc0 after reset", acc0_out, 56'h0);
    chk("R1 acc1 after reset", acc1_out, 56'h0);
    wr(2'd2, 24'h400000);
    op(C_MPY, 2'd0, 2'd1, 1'b0);
    chk("R1 regs zero after reset", acc0_out, 56'h0);
    op(C_MPY, 2'd3, 2'd2, 1'b0);
    chk("R1 reg3 zero after reset", acc0_out, 56'h0);
  endtask

  task automatic t_mac_basic;
    wr(2'd0, 24'h400000); wr(2'd1, 24'h400000);
    wr(2'd2, 24'h200000); wr(2'd3, 24'hC00000);
    op(C_MPY, 2'd0, 2'd1, 1'b0);
    chk("R3 0.5*0.5", acc0_out, 56'h00200000000000);
    chk("R8 acc1 untouched", acc1_out, 56'h0);
    op(C_MAC, 2'd0, 2'd2, 1'b0);
    chk("R4 accumulate", acc0_out, 56'h00300000000000);
    op(C_MACN, 2'd3, 2'd0, 1'b0);
    chk("R5 negative accumulate", acc0_out, 56'h00500000000000);
    step(1'b0, 2'd0, 24'h0, 1'b0, C_MAC, 2'd0, 2'd1, 1'b0);
    chk("R8 idle acc0 holds", acc0_out, 56'h00500000000000);
  endtask

  task automatic t_add_sub;
    op(C_SUB, 2'd0, 2'd3, 1'b1);
    chk("R7 subtract aligned", acc1_out, 56'hFFC00000000000);
    chk("R8 acc0 untouched", acc0_out, 56'h00500000000000);
    op(C_ADD, 2'd2, 2'd0, 1'b1);
    chk("R7 add aligned, src_b ignored", acc1_out, 56'hFFE00000000000);
    wr(2'd3, 24'h800000);
    op(C_MPY, 2'd3, 2'd3, 1'b1);
    chk("R10 -1 times -1", acc1_out, 56'h00800000000000);
  endtask

  task automatic t_rounding;
    wr(2'd2, 24'h000001); wr(2'd1, 24'h600000);
    op(C_MPY, 2'd2, 2'd1, 1'b0);
    chk("R3 low-word product", acc0_out, 56'h00000000C00000);
    op(C_MPYR, 2'd2, 2'd1, 1'b0);
    chk("R6 above half rounds up", acc0_out, 56'h00000001000000);
    wr(2'd1, 24'h400000);
    op(C_MPYR, 2'd2, 2'd1, 1'b0);
    chk("R6 tie to even down", acc0_out, 56'h0);
    op(C_ADD, 2'd2, 2'd0, 1'b0);
    op(C_MACR, 2'd2, 2'd1, 1'b0);
    chk("R6 tie to even up", acc0_out, 56'h00000002000000);
    wr(2'd1, 24'h200000);
    op(C_MPYR, 2'd2, 2'd1, 1'b0);
    chk("R6 below half rounds down", acc0_out, 56'h0);
    wr(2'd1, 24'h400000);
    op(C_ADD, 2'd0, 2'd0, 1'b0);
    op(C_MACNR, 2'd2, 2'd1, 1'b0);
    chk("R6 negative tie to even", acc0_out, 56'h00400000000000);
  endtask

  task automatic t_same_cycle;
    wr(2'd2, 24'h200000);
    step(1'b1, 2'd2, 24'h400000, 1'b1, C_MPY, 2'd2, 2'd2, 1'b1);
    chk("R2 same-edge op sees old value", acc1_out, 56'h00080000000000);
    op(C_MPY, 2'd2, 2'd2, 1'b1);
    chk("R2 new value after write", acc1_out, 56'h00200000000000);
  endtask

  task automatic t_wrap;
    wr(2'd1, 24'h0);
    op(C_MPY, 2'd1, 2'd1, 1'b1);
    chk("R3 zero product", acc1_out, 56'h0);
    wr(2'd0, 24'h7FFFFF);
    for (int i = 0; i < 3; i++) op(C_ADD, 2'd0, 2'd1, 1'b1);
    chk("R9 growth into extension", acc1_out, 56'h017FFFFD000000);
    for (int i = 0; i < 255; i++) op(C_ADD, 2'd0, 2'd1, 1'b1);
    chk("R9 wraps at 56 bits", acc1_out, 56'h80FFFEFE000000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mac_basic();
    t_add_sub();
    t_rounding();
    t_same_cycle();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule